// File: doc/BRIEF.md
# Line-Phase Synchronized Clock Gate

This block gates a slow timing clock (nominally 250 kHz) so that an experiment sequencer driven by that clock can be restarted in step with the mains waveform. While the active-low hold request is released (high), the timing clock runs straight through. When the request is pulled low, the output clock halts in its low phase. It stays halted until two events have occurred in order. The first is a rising zero-crossing of the 60 Hz line, which arrives as a digitized square wave from an external comparator. The second is the next rising edge of a 10 kHz reference clock. The timing clock then resumes, so the halt lasts anywhere from almost nothing up to roughly one line period.

Every input is asynchronous to the fast system clock that runs the block. Each input is brought in through its own multi-flop synchronizer before any edge is detected. The gate enable is allowed to change only while the synchronized timing clock is low. Because of that, the output carries only whole pulses. The output is registered, so it trails the input timing clock by a fixed few system cycles. A status flag tells the sequencer that a halt is in progress.

Top module: `line_sync_clock_gate`

## Requirements
- R1: After reset the block is in pass-through, `waiting` is 0, and `clk_out` is 0.
- R2: While `hold_n` stays high, `clk_out` reproduces every pulse of `tclk_in`: over any window of N whole input periods it shows exactly N rising edges.
- R3: A falling edge of `hold_n` arms the block. `waiting` goes to 1, and `clk_out` stays at 0 after it finishes the current high phase.
- R4: While armed, rising edges of `ref_in` are ignored until a rising edge of `line_in` has been latched.
- R5: After the line edge is latched, the next rising edge of `ref_in` releases the gate. `waiting` returns to 0 and `clk_out` runs again.
- R6: After release the clock keeps passing while `hold_n` remains low. A new halt needs `hold_n` to go high and then fall again.
- R7: Every high pulse on `clk_out` lasts exactly as long as a high phase of `tclk_in` (measured in system cycles); no shortened pulse appears.
- R8: If the line edge and a reference edge reach the block in the same system cycle, the line edge is latched, the gate stays closed, and release waits for a later reference edge.
- R9: If `hold_n` returns high while the block is armed or waiting for the reference, the halt is cancelled. `waiting` drops and pass-through resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples all other inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| tclk_in | input | 1 | Timing clock to be gated (asynchronous) |
| hold_n | input | 1 | Active-low halt request (asynchronous) |
| line_in | input | 1 | Digitized 60 Hz line square wave, rising at the upward zero-crossing |
| ref_in | input | 1 | 10 kHz reference clock (asynchronous) |
| clk_out | output | 1 | Gated timing clock, registered on `clk` |
| waiting | output | 1 | High from the arming edge until release or cancel |

## Verification
Pulse counts over whole-period windows separate free running from halted. Running them after each stimulus shows when the gate opens and when it closes. In one pattern the reference edges come before the line edge, and in another they come after it; together these show that the two events are taken in order and not as a plain AND of two flags. A line edge and a reference edge that coincide show whether a same-cycle reference edge is wrongly treated as the release. Other patterns raise the hold request during a wait, or lower it again after release, which checks cancel and re-arm. Every output pulse is timed against the input high phase, and halts start at different clock phases, so a runt left by a badly timed enable change would show up as a short pulse.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LINE  = 2'd2,
    ST_RUN   = 2'd3
  } lsg_state_e;

  localparam int IDX_TCLK = 0;
  localparam int IDX_HOLD = 1;
  localparam int IDX_LINE = 2;
  localparam int IDX_REF  = 3;
  localparam int N_INPUTS = 4;
endpackage

// File: rtl/lsg_sync.sv
module lsg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= async_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign sync_out = chain[LAST];
endmodule

// File: rtl/lsg_edge.sv
module lsg_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= level;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign rise[i] = level[i] & ~prev[i];
      assign fall[i] = ~level[i] & prev[i];
    end
  endgenerate
endmodule

// File: rtl/lsg_ctrl.sv
module lsg_ctrl
  import lsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_rise,
  input  logic hold_fall,
  input  logic line_rise,
  input  logic ref_rise,
  output logic want_en,
  output logic waiting
);
  lsg_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_PASS:  if (hold_fall) state_nx = ST_ARMED;
      ST_ARMED: begin
        if (hold_rise)      state_nx = ST_PASS;
        else if (line_rise) state_nx = ST_LINE;
      end
      ST_LINE: begin
        if (hold_rise)     state_nx = ST_PASS;
        else if (ref_rise) state_nx = ST_RUN;
      end
      ST_RUN:   if (hold_rise) state_nx = ST_PASS;
      default:  state_nx = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PASS;
    else        state <= state_nx;
  end

  assign want_en = (state == ST_PASS) || (state == ST_RUN);
  assign waiting = (state == ST_ARMED) || (state == ST_LINE);

  // Release only follows a latched line edge.
  assert_release_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(state) == ST_LINE);

  // A reference edge while armed never opens the gate.
  assert_ref_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !hold_rise) |=> state != ST_RUN);

  // Coinciding line and reference edges only latch the line.
  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && line_rise && ref_rise && !hold_rise) |=> state == ST_LINE);

  // Released gate stays released until the request goes high.
  assert_stay_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !hold_rise) |=> state == ST_RUN);

  // Request high during a wait cancels it.
  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && hold_rise) |=> (state == ST_PASS));
endmodule

// File: rtl/lsg_gate.sv
module lsg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_s,
  input  logic want_en,
  output logic clk_out
);
  logic en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b1;
      clk_out <= 1'b0;
    end else begin
      if (!tclk_s) en <= want_en;
      clk_out <= tclk_s & en;
    end
  end

  // Enable moves only during the low phase of the timing clock.
  assert_no_runt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en != $past(en)) |-> !$past(tclk_s));

  // A closed gate holds the output low.
  assert_held_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !clk_out);

  // Output can only be high while the timing clock was high.
  assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> $past(tclk_s));
endmodule

// File: rtl/line_sync_clock_gate.sv
module line_sync_clock_gate
  import lsg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_in,
  input  logic hold_n,
  input  logic line_in,
  input  logic ref_in,
  output logic clk_out,
  output logic waiting
);
  logic [N_INPUTS-1:0] raw, synced, rise, fall;
  logic                want_en;

  assign raw[IDX_TCLK] = tclk_in;
  assign raw[IDX_HOLD] = hold_n;
  assign raw[IDX_LINE] = line_in;
  assign raw[IDX_REF]  = ref_in;

  lsg_sync #(.W(N_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw),
    .sync_out (synced)
  );

  lsg_edge #(.W(N_INPUTS)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (synced),
    .rise  (rise),
    .fall  (fall)
  );

  lsg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_rise (rise[IDX_HOLD]),
    .hold_fall (fall[IDX_HOLD]),
    .line_rise (rise[IDX_LINE]),
    .ref_rise  (rise[IDX_REF]),
    .want_en   (want_en),
    .waiting   (waiting)
  );

  lsg_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .tclk_s  (synced[IDX_TCLK]),
    .want_en (want_en),
    .clk_out (clk_out)
  );

  // While halted the gated output stays low.
  assert_wait_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && $past(waiting) && $past(waiting, 2) && !$past(synced[IDX_TCLK]))
      |-> !clk_out);
endmodule

// File: tb/test_line_sync_clock_gate.sv
module test_line_sync_clock_gate;
  localparam int PERIOD = 10;
  localparam int HALF   = 20;
  localparam int WIN    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tclk_in = 1'b0, hold_n = 1'b1, line_in = 1'b0, ref_in = 1'b0;
  logic clk_out, waiting;

  int checks = 0, failures = 0;
  int edges = 0, hi_len = 0, runts = 0, pulses = 0;
  bit done = 0;

  line_sync_clock_gate i_line_sync_clock_gate (
    .clk(clk), .rst_n(rst_n), .tclk_in(tclk_in), .hold_n(hold_n),
    .line_in(line_in), .ref_in(ref_in), .clk_out(clk_out), .waiting(waiting)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (HALF) @(negedge clk);
      tclk_in = ~tclk_in;
    end
  end

  always @(posedge clk_out) edges++;

  // R7: time every output high pulse
  always @(negedge clk) begin
    if (clk_out) hi_len++;
    else if (hi_len != 0) begin
      pulses++;
      if (hi_len != HALF) runts++;
      hi_len = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_window(output int n);
    edges = 0;
    repeat (WIN * 2 * HALF) @(negedge clk);
    n = edges;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    repeat (6) @(negedge clk); sig = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic settle();
    repeat (100) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(waiting == 1'b0, "R1 waiting", waiting, 0);
    check(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
  endtask

  task automatic t_pass();
    int n;
    count_window(n);
    check(n == WIN, "R2 pass-through edges", n, WIN);
  endtask

  task automatic t_arm_and_order();
    int n;
    @(negedge clk); hold_n = 1'b0;
    settle();
    check(waiting == 1'b1, "R3 waiting after arm", waiting, 1);
    count_window(n);
    check(n == 0, "R3 halted edges", n, 0);
    pulse(ref_in);
    pulse(ref_in);
    count_window(n);
    check(n == 0, "R4 ref before line ignored", n, 0);
    check(waiting == 1'b1, "R4 still waiting", waiting, 1);
    pulse(line_in);
    count_window(n);
    check(n == 0, "R5 line alone holds", n, 0);
    pulse(ref_in);
    settle();
    check(waiting == 1'b0, "R5 waiting cleared", waiting, 0);
    count_window(n);
    check(n == WIN, "R5 released edges", n, WIN);
  endtask

  task automatic t_stay_and_rearm();
    int n;
    pulse(line_in);
    pulse(ref_in);
    count_window(n);
    check(n == WIN, "R6 runs while hold low", n, WIN);
    check(waiting == 1'b0, "R6 no new wait", waiting, 0);
    @(negedge clk); hold_n = 1'b1;
    settle();
    repeat (7) @(negedge clk);
    hold_n = 1'b0;
    settle();
    count_window(n);
    check(n == 0, "R6 re-armed halt", n, 0);
    check(waiting == 1'b1, "R6 re-armed waiting", waiting, 1);
  endtask

  task automatic t_same_cycle();
    int n;
    @(negedge clk); line_in = 1'b1; ref_in = 1'b1;
    repeat (6) @(negedge clk); line_in = 1'b0; ref_in = 1'b0;
    settle();
    check(waiting == 1'b1, "R8 still waiting", waiting, 1);
    count_window(n);
    check(n == 0, "R8 gate closed", n, 0);
    pulse(ref_in);
    settle();
    count_window(n);
    check(n == WIN, "R8 later ref releases", n, WIN);
  endtask

  task automatic t_cancel();
    int n;
    @(negedge clk); hold_n = 1'b1;
    settle();
    repeat (13) @(negedge clk);
    hold_n = 1'b0;
    settle();
    check(waiting == 1'b1, "R9 armed", waiting, 1);
    pulse(line_in);
    @(negedge clk); hold_n = 1'b1;
    settle();
    check(waiting == 1'b0, "R9 cancel clears waiting", waiting, 0);
    count_window(n);
    check(n == WIN, "R9 pass resumes", n, WIN);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_pass();
    t_arm_and_order();
    t_stay_and_rearm();
    t_same_cycle();
    t_cancel();
    check(runts == 0, "R7 runt pulses", runts, 0);
    check(pulses > 0, "R7 pulses seen", pulses, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule